// File: doc/BRIEF.md
# Reusable Sense-Reversing Barrier

This block holds P requesters at a common synchronization point. Each requester reports that it has reached the point with a single-cycle pulse on its arrival line. It then waits until all P requesters have arrived. When the last one arrives, every requester sees its done output rise in the same cycle. Done stays high until that requester acknowledges it.

The barrier can be used again straight away. Each requester keeps a private sense bit and inverts it each time it enters. The completing arrival inverts a shared flag, so the flag then equals the sense of every requester in that round. A requester that has acknowledged can enter the next round before the others have acknowledged the previous one. No second wait phase or leave counter is needed.

Arrivals that land in the same cycle are all counted. A pulse from a requester that is already waiting, whether still blocked or released but not yet acknowledged, is dropped.

Top module: `barrier_sync`

## Requirements
- R1: After reset no done bit is high, the arrival count is zero, and the flag and all sense bits are 0. An arrival made before a reset does not count toward the first round after it.
- R2: A requester that has arrived keeps done low while fewer than P distinct requesters have arrived in the current round.
- R3: The clock edge that accepts the P-th arrival of a round makes done high, on the following cycle, for all P requesters. Bit i of every vector belongs to requester i.
- R4: Arrivals from several requesters in one cycle are each counted. P arrivals in one cycle complete the round at that edge.
- R5: A high done bit stays high until its own ack bit is sampled high. It then drops at that edge, and the other done bits are not affected.
- R6: An arrival pulse from a requester that is waiting, either blocked or done but not yet acknowledged, is ignored and does not add to the count.
- R7: A requester that has acknowledged may arrive for the next round while others still hold done. It stays blocked until all P have arrived in that new round.
- R8: An ack bit sampled while the matching done bit is low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| arrive | input | P | One-cycle arrival pulse per requester |
| ack | input | P | Acknowledge of done per requester |
| done | output | P | Release indication per requester, registered |

## Verification
A corrupted arrival count shows up as a round that completes early or late. The done vector then rises one or more cycles away from the edge that accepts the P-th distinct arrival, and the bench samples the cycle right after every arrival. A sense bit or flag out of step shows as a requester that is released alone or never released. The next round reveals it, because the rounds alternate the flag polarity. An error in the waiting bits shows within one cycle, as a done that drops without its ack or a repeat pulse that is counted.

// File: rtl/barrier_sync.sv
module barrier_sync #(
  parameter int P = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [P-1:0] arrive,
  input  logic [P-1:0] ack,
  output logic [P-1:0] done
);
  localparam int CW = $clog2(P + 1);

  logic [CW-1:0] count;
  logic          flag;
  logic [P-1:0]  sense;
  logic [P-1:0]  waiting;
  logic [P-1:0]  take;
  logic [CW-1:0] joins;
  logic [CW:0]   total;
  logic          last;

  assign take  = arrive & ~waiting;
  assign total = {1'b0, count} + {1'b0, joins};
  assign last  = (total == (CW + 1)'(P));
  assign done  = waiting & ~(sense ^ {P{flag}});

  always_comb begin
    joins = '0;
    for (int i = 0; i < P; i++) joins = joins + CW'(take[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      flag    <= 1'b0;
      sense   <= '0;
      waiting <= '0;
    end else begin
      count   <= last ? '0 : total[CW-1:0];
      if (last) flag <= ~flag;
      sense   <= sense ^ take;
      waiting <= (waiting & ~(ack & done)) | take;
    end
  end
endmodule

// File: rtl/barrier_sync_chk.sv
module barrier_sync_chk #(
  parameter int P = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [P-1:0]               ack,
  input logic [P-1:0]               done,
  input logic [$clog2(P+1)-1:0]     count,
  input logic                       flag
);
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count < ($clog2(P+1))'(P));

  a_r5_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done & ~ack) != '0 |=> (done & $past(done & ~ack)) == $past(done & ~ack));

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done & ack) != '0 |=> (done & $past(done & ack)) == '0);

  a_r3_release_on_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (done & ~$past(done)) != '0 |-> flag != $past(flag));
endmodule

bind barrier_sync barrier_sync_chk #(.P(P)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .ack   (ack),
  .done  (done),
  .count (count),
  .flag  (flag)
);

// File: tb/test_barrier_sync.sv
module test_barrier_sync;
  localparam int P = 4;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [P-1:0] arrive = '0;
  logic [P-1:0] ack = '0;
  logic [P-1:0] done;

  int checks = 0;
  int fails = 0;

  barrier_sync #(.P(P)) i_barrier_sync (
    .clk(clk), .rst_n(rst_n), .arrive(arrive), .ack(ack), .done(done)
  );

  always #2.5 clk = ~clk;

  // {req, arrive, ack, expected done after the edge}
  localparam logic [15:0] VEC [N] = '{
    {4'd2, 4'b0001, 4'b0000, 4'b0000},  // R2 first arrival
    {4'd6, 4'b0001, 4'b0000, 4'b0000},  // R6 repeat pulse ignored
    {4'd4, 4'b0110, 4'b0000, 4'b0000},  // R4 two at once, count 3
    {4'd6, 4'b0001, 4'b0000, 4'b0000},  // R6 repeat would complete if counted
    {4'd3, 4'b1000, 4'b0000, 4'b1111},  // R3 last arrival releases all
    {4'd5, 4'b0000, 4'b0011, 4'b1100},  // R5 ack clears only its own bits
    {4'd5, 4'b0000, 4'b0000, 4'b1100},  // R5 done holds without ack
    {4'd7, 4'b0011, 4'b0000, 4'b1100},  // R7 early entry into next round
    {4'd6, 4'b1100, 4'b0000, 4'b1100},  // R6 pulse while done ignored
    {4'd7, 4'b0000, 4'b1100, 4'b0000},  // R7 early entrants still blocked
    {4'd7, 4'b1100, 4'b0000, 4'b1111},  // R7 second round completes
    {4'd5, 4'b0000, 4'b1111, 4'b0000},  // R5 all acked
    {4'd4, 4'b1111, 4'b0000, 4'b1111},  // R4 all P in one cycle
    {4'd5, 4'b0000, 4'b0100, 4'b1011},  // R5 single ack
    {4'd5, 4'b0000, 4'b1011, 4'b0000},  // R5 remaining acks
    {4'd8, 4'b0000, 4'b1111, 4'b0000}   // R8 ack with done low
  };

  task automatic check(input int req, input logic [P-1:0] exp);
    checks++;
    if (done !== exp) begin
      fails++;
      $display("FAIL R%0d: done=%b expected %b at %0t", req, done, exp, $time);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(1, '0);  // R1 reset state
    rst_n = 1'b1;
    @(negedge clk);
    check(1, '0);  // R1 idle after reset

    for (int k = 0; k < N; k++) begin
      arrive = VEC[k][11:8];
      ack    = VEC[k][7:4];
      @(negedge clk);
      check(int'(VEC[k][15:12]), VEC[k][3:0]);
      arrive = '0;
      ack    = '0;
    end

    // R8: following idle cycle after stray ack, round still fresh
    arrive = 4'b0111;
    @(negedge clk);
    arrive = '0;
    check(2, '0);  // R2 three of four waiting
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(1, '0);  // R1 reset drops partial round
    rst_n = 1'b1;
    arrive = 4'b1000;
    @(negedge clk);
    arrive = '0;
    check(1, '0);  // R1 earlier arrivals discarded
    arrive = 4'b0111;
    @(negedge clk);
    arrive = '0;
    check(3, 4'b1111);  // R3 round completes from clean count
    ack = 4'b1111;
    @(negedge clk);
    ack = '0;
    check(5, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule